// File: doc/BRIEF.md
# Channel-Gain List Scan Sequencer

The sequencer keeps a short list of channel and gain pairs and walks through it to steer an analog input path. Each time a conversion is issued it presents the selected multiplexer channel, the amplifier gain code and the matching gain factor, and raises a one-cycle conversion-start strobe. A host fills the list through a write port, sets the last active address, and can read back the address of the entry most recently issued.

Three sequencing modes decide what a start request does. In single mode every start issues the next entry of the list. In continuous mode a start rewinds to entry 0 and pacer ticks then issue entries in a loop that never ends. In scan mode a start rewinds to entry 0 and pacer ticks issue exactly one pass up to the last active address, after which the sequencer waits for the next start. A start comes from a software strobe or from an external trigger when that trigger is enabled. A conversion requested while the converter reports busy is refused and latched as an error.

Top module: `cgl_scan_seq`

## Requirements
- R1: After reset every list entry holds channel 0 and gain code 0, the last active address reads 15, the presented address, channel and gain code are 0, and conv_start, scan_done, trig_err and scan_active are 0.
- R2: While ld_en is 1, each ld_wr pulse stores {ld_chan, ld_gain} into the next list location; the write pointer starts at 0 after reset or after an ld_rst pulse and wraps from 15 to 0. An ld_rst in the same cycle as ld_wr wins and no entry is written.
- R3: An ld_wr pulse while ld_en is 0 changes no list entry and does not advance the write pointer.
- R4: gain_factor shows the gain selected by gain_code: codes 0, 1, 2 and 3 give 1, 2, 4 and 8.
- R5: A fin_wr pulse loads fin_data into the last active address, read back on fin_addr_q one cycle later; after issuing the entry at that address the sequencer continues at entry 0.
- R6: With mode 0 (single), each start issues the entry at the read pointer: one cycle after the start, conv_start is 1 for one cycle while mux_chan, gain_code and cur_addr show that entry, and the pointer then moves to the next entry.
- R7: A start is sw_start, or ext_trig while ext_trig_en is 1; ext_trig with ext_trig_en at 0 has no effect.
- R8: With mode 1 (continuous), a start sets the pointer to 0 and raises scan_active without issuing; each pacer_tick while scan_active is 1 then issues the next entry, looping without end. Pacer ticks while scan_active is 0 issue nothing.
- R9: With mode 2 (scan), a start sets the pointer to 0 and raises scan_active; pacer ticks issue entries 0 through the last active address, and scan_active drops in the cycle the last one is issued, so later ticks issue nothing until the next start.
- R10: scan_done is 1 for exactly the cycle in which conv_start presents the entry at the last active address, in every mode.
- R11: A conversion requested while conv_busy is 1 is not issued, leaves the pointer unchanged and sets trig_err, which stays set until an err_clr pulse.
- R12: With mode 3 (off), nothing is issued; scan_active is cleared whenever the mode is 0 or 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_rst | input | 1 | Rewind the list write pointer to 0 |
| ld_en | input | 1 | Allow list writes |
| ld_wr | input | 1 | Write one list entry |
| ld_chan | input | 4 | Channel for the entry being written |
| ld_gain | input | 2 | Gain code for the entry being written |
| fin_wr | input | 1 | Load the last active address |
| fin_data | input | 4 | New last active address |
| fin_addr_q | output | 4 | Last active address readback |
| mode | input | 2 | 0 single, 1 continuous, 2 scan, 3 off |
| sw_start | input | 1 | Software start strobe |
| ext_trig | input | 1 | External trigger strobe |
| ext_trig_en | input | 1 | Let the external trigger act as a start |
| pacer_tick | input | 1 | Pacer clock tick |
| conv_busy | input | 1 | Converter still busy |
| err_clr | input | 1 | Clear the trigger error flag |
| cur_addr | output | 4 | List address of the entry last issued |
| mux_chan | output | 4 | Selected input channel |
| gain_code | output | 2 | Selected gain code |
| gain_factor | output | 4 | Selected gain as a number (1, 2, 4 or 8) |
| conv_start | output | 1 | One-cycle conversion start strobe |
| scan_done | output | 1 | Last active entry issued this cycle |
| trig_err | output | 1 | Sticky busy-conflict error |
| scan_active | output | 1 | Continuous or scan sequence armed |

## Verification
On every cycle the assertions check that no strobe is issued against a busy converter, that the error flag only rises after a busy conflict, that scan_done coincides with the strobe for the last active address, that clocked issues follow a tick while armed, that single-mode issues follow a start, that a scan disarms on its last entry and that the off mode stays silent. Which entry is issued, the order in which the list is walked, wrap-around at a changed last address, the contents left by ignored writes and the rewind on start can only be shown by the bench scenarios, which compare the presented channel, gain and address with a model of the loaded list.

// File: rtl/cgl_pkg.sv
package cgl_pkg;

    localparam int CGL_DEPTH  = 16;
    localparam int CGL_CHAN_W = 4;
    localparam int CGL_GAIN_W = 2;
    localparam int CGL_FACT_W = 1 << CGL_GAIN_W;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'd0,
        MODE_CONT   = 2'd1,
        MODE_SCAN   = 2'd2,
        MODE_OFF    = 2'd3
    } seq_mode_e;

    typedef struct packed {
        logic [CGL_CHAN_W-1:0] chan;
        logic [CGL_GAIN_W-1:0] gain;
    } cg_entry_t;

    // Gain code n selects an amplification of 2**n.
    function automatic logic [CGL_FACT_W-1:0] gain_to_factor(input logic [CGL_GAIN_W-1:0] code);
        return CGL_FACT_W'(1) << code;
    endfunction

    function automatic logic clocked_mode(input seq_mode_e m);
        return (m == MODE_CONT) || (m == MODE_SCAN);
    endfunction

endpackage

// File: rtl/cgl_list_store.sv
module cgl_list_store
    import cgl_pkg::*;
#(
    parameter int DEPTH = CGL_DEPTH,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_rst,
    input  logic          ld_en,
    input  logic          ld_wr,
    input  cg_entry_t     wr_entry,
    input  logic [AW-1:0] rd_addr,
    output cg_entry_t     rd_entry
);

    cg_entry_t     mem [DEPTH];
    logic [AW-1:0] wptr;
    logic          wr_go;

    assign wr_go = ld_en && ld_wr && !ld_rst;

    always_ff @(posedge clk) begin
        if (rst || ld_rst) begin
            wptr <= '0;
        end else if (wr_go) begin
            wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_go) begin
            mem[wptr] <= wr_entry;
        end
    end

    assign rd_entry = mem[rd_addr];

endmodule

// File: rtl/cgl_issue_ctrl.sv
module cgl_issue_ctrl
    import cgl_pkg::*;
#(
    parameter int DEPTH = CGL_DEPTH,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  seq_mode_e     mode,
    input  logic          start,
    input  logic          pacer_tick,
    input  logic          conv_busy,
    input  logic          err_clr,
    input  logic [AW-1:0] last_addr,
    output logic [AW-1:0] rd_addr,
    input  cg_entry_t     rd_entry,
    output logic [AW-1:0] cur_addr,
    output cg_entry_t     cur_entry,
    output logic          conv_start,
    output logic          scan_done,
    output logic          trig_err,
    output logic          active
);

    logic [AW-1:0] ptr;
    logic          rewind;
    logic          req;
    logic          at_last;

    assign rd_addr = ptr;
    assign at_last = (ptr == last_addr) || (ptr == AW'(DEPTH - 1));

    always_comb begin
        rewind = start && clocked_mode(mode);
        req    = ((mode == MODE_SINGLE) && start)
              || (clocked_mode(mode) && active && pacer_tick && !start);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr        <= '0;
            cur_addr   <= '0;
            cur_entry  <= '0;
            conv_start <= 1'b0;
            scan_done  <= 1'b0;
            trig_err   <= 1'b0;
            active     <= 1'b0;
        end else begin
            conv_start <= 1'b0;
            scan_done  <= 1'b0;
            trig_err   <= (trig_err && !err_clr) || (req && conv_busy);
            if (!clocked_mode(mode)) begin
                active <= 1'b0;
            end
            if (rewind) begin
                ptr    <= '0;
                active <= 1'b1;
            end else if (req && !conv_busy) begin
                cur_entry  <= rd_entry;
                cur_addr   <= ptr;
                conv_start <= 1'b1;
                scan_done  <= (ptr == last_addr);
                ptr        <= at_last ? '0 : ptr + 1'b1;
                if ((mode == MODE_SCAN) && (ptr == last_addr)) begin
                    active <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/cgl_scan_seq.sv
module cgl_scan_seq
    import cgl_pkg::*;
#(
    parameter int DEPTH = CGL_DEPTH,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ld_rst,
    input  logic                  ld_en,
    input  logic                  ld_wr,
    input  logic [CGL_CHAN_W-1:0] ld_chan,
    input  logic [CGL_GAIN_W-1:0] ld_gain,
    input  logic                  fin_wr,
    input  logic [AW-1:0]         fin_data,
    output logic [AW-1:0]         fin_addr_q,
    input  logic [1:0]            mode,
    input  logic                  sw_start,
    input  logic                  ext_trig,
    input  logic                  ext_trig_en,
    input  logic                  pacer_tick,
    input  logic                  conv_busy,
    input  logic                  err_clr,
    output logic [AW-1:0]         cur_addr,
    output logic [CGL_CHAN_W-1:0] mux_chan,
    output logic [CGL_GAIN_W-1:0] gain_code,
    output logic [CGL_FACT_W-1:0] gain_factor,
    output logic                  conv_start,
    output logic                  scan_done,
    output logic                  trig_err,
    output logic                  scan_active
);

    cg_entry_t     wr_entry;
    cg_entry_t     rd_entry;
    cg_entry_t     cur_entry;
    logic [AW-1:0] rd_addr;
    logic          start;
    seq_mode_e     mode_e;

    assign wr_entry = '{chan: ld_chan, gain: ld_gain};
    assign start    = sw_start || (ext_trig && ext_trig_en);
    assign mode_e   = seq_mode_e'(mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            fin_addr_q <= AW'(DEPTH - 1);
        end else if (fin_wr) begin
            fin_addr_q <= fin_data;
        end
    end

    cgl_list_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .ld_rst   (ld_rst),
        .ld_en    (ld_en),
        .ld_wr    (ld_wr),
        .wr_entry (wr_entry),
        .rd_addr  (rd_addr),
        .rd_entry (rd_entry)
    );

    cgl_issue_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode_e),
        .start      (start),
        .pacer_tick (pacer_tick),
        .conv_busy  (conv_busy),
        .err_clr    (err_clr),
        .last_addr  (fin_addr_q),
        .rd_addr    (rd_addr),
        .rd_entry   (rd_entry),
        .cur_addr   (cur_addr),
        .cur_entry  (cur_entry),
        .conv_start (conv_start),
        .scan_done  (scan_done),
        .trig_err   (trig_err),
        .active     (scan_active)
    );

    assign mux_chan    = cur_entry.chan;
    assign gain_code   = cur_entry.gain;
    assign gain_factor = gain_to_factor(cur_entry.gain);

endmodule

// File: rtl/cgl_scan_seq_chk.sv
module cgl_scan_seq_chk
    import cgl_pkg::*;
#(
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    mode,
    input logic          sw_start,
    input logic          ext_trig,
    input logic          ext_trig_en,
    input logic          pacer_tick,
    input logic          conv_busy,
    input logic [AW-1:0] fin_addr_q,
    input logic [AW-1:0] cur_addr,
    input logic          conv_start,
    input logic          scan_done,
    input logic          trig_err,
    input logic          scan_active
);

    assert_no_busy_issue_R11: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> !$past(conv_busy));

    assert_err_cause_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(trig_err) |-> $past(conv_busy));

    assert_done_on_last_R10: assert property (@(posedge clk) disable iff (rst)
        scan_done |-> (conv_start && (cur_addr == $past(fin_addr_q))));

    assert_single_needs_start_R6: assert property (@(posedge clk) disable iff (rst)
        (conv_start && ($past(mode) == MODE_SINGLE)) |-> $past(sw_start || (ext_trig && ext_trig_en)));

    assert_cont_needs_tick_R8: assert property (@(posedge clk) disable iff (rst)
        (conv_start && ($past(mode) == MODE_CONT)) |-> ($past(scan_active) && $past(pacer_tick)));

    assert_scan_disarms_R9: assert property (@(posedge clk) disable iff (rst)
        (scan_done && ($past(mode) == MODE_SCAN)) |-> !scan_active);

    assert_off_silent_R12: assert property (@(posedge clk) disable iff (rst)
        ($past(mode) == MODE_OFF) |-> !conv_start);

endmodule

bind cgl_scan_seq cgl_scan_seq_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .mode        (mode),
    .sw_start    (sw_start),
    .ext_trig    (ext_trig),
    .ext_trig_en (ext_trig_en),
    .pacer_tick  (pacer_tick),
    .conv_busy   (conv_busy),
    .fin_addr_q  (fin_addr_q),
    .cur_addr    (cur_addr),
    .conv_start  (conv_start),
    .scan_done   (scan_done),
    .trig_err    (trig_err),
    .scan_active (scan_active)
);

// File: tb/cgl_scan_seq_test.sv
module cgl_scan_seq_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ld_rst = 1'b0, ld_en = 1'b0, ld_wr = 1'b0;
    logic [3:0] ld_chan = '0;
    logic [1:0] ld_gain = '0;
    logic       fin_wr = 1'b0;
    logic [3:0] fin_data = '0;
    logic [3:0] fin_addr_q;
    logic [1:0] mode = 2'd0;
    logic       sw_start = 1'b0, ext_trig = 1'b0, ext_trig_en = 1'b0;
    logic       pacer_tick = 1'b0, conv_busy = 1'b0, err_clr = 1'b0;
    logic [3:0] cur_addr, mux_chan, gain_factor;
    logic [1:0] gain_code;
    logic       conv_start, scan_done, trig_err, scan_active;

    int tests = 0;
    int fails = 0;
    int eptr  = 0;
    int efin  = 15;

    // {chan, gain} for list locations 0..7
    localparam logic [5:0] VEC [8] = '{6'd20, 6'd13, 6'd50, 6'd3, 6'd61, 6'd30, 6'd36, 6'd7};

    always #2 clk = ~clk;

    cgl_scan_seq uut (
        .clk(clk), .rst(rst), .ld_rst(ld_rst), .ld_en(ld_en), .ld_wr(ld_wr),
        .ld_chan(ld_chan), .ld_gain(ld_gain), .fin_wr(fin_wr), .fin_data(fin_data),
        .fin_addr_q(fin_addr_q), .mode(mode), .sw_start(sw_start), .ext_trig(ext_trig),
        .ext_trig_en(ext_trig_en), .pacer_tick(pacer_tick), .conv_busy(conv_busy),
        .err_clr(err_clr), .cur_addr(cur_addr), .mux_chan(mux_chan), .gain_code(gain_code),
        .gain_factor(gain_factor), .conv_start(conv_start), .scan_done(scan_done),
        .trig_err(trig_err), .scan_active(scan_active)
    );

    // Expected list contents once loading is complete: 0..7 from VEC, 8 = {2,2}, rest reset value.
    function automatic logic [5:0] model_entry(input int a);
        if (a < 8) return VEC[a];
        if (a == 8) return 6'd10;
        return 6'd0;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic pulse_start();
        sw_start = 1'b1; step(); sw_start = 1'b0;
    endtask

    task automatic pulse_tick();
        pacer_tick = 1'b1; step(); pacer_tick = 1'b0;
    endtask

    task automatic load(input logic [5:0] e, input logic en);
        ld_en = en; ld_chan = e[5:2]; ld_gain = e[1:0]; ld_wr = 1'b1;
        step(); ld_wr = 1'b0; ld_en = 1'b0;
    endtask

    task automatic set_fin(input int v);
        fin_data = 4'(v); fin_wr = 1'b1; step(); fin_wr = 1'b0; efin = v;
    endtask

    // Compare the presented entry with the model for an issue at the expected pointer.
    task automatic expect_issue(input string tag);
        logic [5:0] e;
        e = model_entry(eptr);
        check({tag, " conv_start"}, int'(conv_start), 1);
        check({tag, " addr"}, int'(cur_addr), eptr);
        check({tag, " chan"}, int'(mux_chan), int'(e[5:2]));
        check({tag, " gain"}, int'(gain_code), int'(e[1:0]));
        check({tag, " R4 factor"}, int'(gain_factor), 1 << e[1:0]);
        check({tag, " R10 done"}, int'(scan_done), int'(eptr == efin));
        eptr = (eptr == efin) ? 0 : eptr + 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        // R1 reset state
        check("R1 fin_addr_q", int'(fin_addr_q), 15);
        check("R1 cur_addr", int'(cur_addr), 0);
        check("R1 chan", int'(mux_chan), 0);
        check("R1 conv_start", int'(conv_start), 0);
        check("R1 scan_done", int'(scan_done), 0);
        check("R1 trig_err", int'(trig_err), 0);
        check("R1 scan_active", int'(scan_active), 0);

        // R2 load the table, R5 final address
        ld_rst = 1'b1; step(); ld_rst = 1'b0;
        for (int i = 0; i < 8; i++) load(VEC[i], 1'b1);
        set_fin(7);
        check("R5 fin readback", int'(fin_addr_q), 7);

        // R6 single mode walk over the table with wrap after the final address
        for (int i = 0; i < 10; i++) begin
            pulse_start();
            expect_issue("R6 single");
        end

        // R7 external trigger gated by its enable
        ext_trig = 1'b1; step(); ext_trig = 1'b0;
        check("R7 trig ignored", int'(conv_start), 0);
        ext_trig_en = 1'b1; ext_trig = 1'b1; step(); ext_trig = 1'b0; ext_trig_en = 1'b0;
        expect_issue("R7 trig used");

        // R3 disabled write must neither store nor advance the pointer
        load({4'd14, 2'd3}, 1'b0);
        load({4'd2, 2'd2}, 1'b1);
        set_fin(9);
        for (int i = 0; i < 8; i++) begin
            pulse_start();
            expect_issue("R3 R5 walk");
        end

        // R11 busy conflict
        conv_busy = 1'b1; pulse_start(); conv_busy = 1'b0;
        check("R11 no issue", int'(conv_start), 0);
        check("R11 err set", int'(trig_err), 1);
        pulse_start();
        expect_issue("R11 pointer kept");
        check("R11 err sticky", int'(trig_err), 1);
        err_clr = 1'b1; step(); err_clr = 1'b0;
        check("R11 err cleared", int'(trig_err), 0);

        // R8 continuous mode
        mode = 2'd1;
        pulse_tick();
        check("R8 tick before start", int'(conv_start), 0);
        pulse_start();
        check("R8 start no issue", int'(conv_start), 0);
        check("R8 armed", int'(scan_active), 1);
        eptr = 0;
        for (int i = 0; i < 12; i++) begin
            pulse_tick();
            expect_issue("R8 loop");
        end
        pulse_start();
        eptr = 0;
        pulse_tick();
        expect_issue("R8 rewind");

        // R12 off mode
        mode = 2'd3;
        step();
        check("R12 disarmed", int'(scan_active), 0);
        pulse_tick();
        check("R12 tick silent", int'(conv_start), 0);
        pulse_start();
        check("R12 start silent", int'(conv_start), 0);

        // R9 triggered scan, one pass per start
        mode = 2'd2;
        set_fin(3);
        pulse_start();
        check("R9 armed", int'(scan_active), 1);
        eptr = 0;
        for (int i = 0; i < 4; i++) begin
            pulse_tick();
            expect_issue("R9 pass");
        end
        check("R9 idle after pass", int'(scan_active), 0);
        pulse_tick();
        check("R9 tick ignored", int'(conv_start), 0);
        pulse_start();
        eptr = 0;
        pulse_tick();
        expect_issue("R9 second pass");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule